// File: doc/BRIEF.md
# Path Overhead Byte Insertion Unit

This block sits in the transmit byte stream of an STS-1 path, one byte per clock. Position strobes tell it where each byte falls: the first byte of a frame, bytes of the synchronous payload envelope, and the path overhead column together with a row index. For every path overhead byte it either forwards the incoming byte or substitutes a value held in its register bank. The choice is made per byte position under one path-insert enable.

When insertion is on, the block does four things. It recomputes the path BIP-8 over the envelope bytes it sent in the previous frame and XORs that result with a corruption mask. The mask is either applied on one frame only or on every frame. It places a clamped far-end block error count in the upper nibble of the status byte. It plays the trace byte out of a 64-entry circular buffer. When insertion is off, each incoming trace byte is stored into that buffer instead. A simple synchronous host write port loads the registers and the trace buffer. Framing and pointer processing are handled elsewhere.

Top module: `pohInsert`

## Requirements
- R1: With the path-insert bit (bit 0 of the control register at 0x1D1) set, the overhead bytes at rows C2 (row code 2), F2 (4), Z3 (6), Z4 (7) and Z5 (8) are replaced by the registers at 0x1C9, 0x1CB, 0x1CD, 0x1CE and 0x1CF. With that bit clear, every byte leaves unchanged.
- R2: The H4 byte (row code 5) always leaves unchanged, whatever the register contents.
- R3: The trace buffer has 64 entries and a pointer that starts at 0 after reset. The pointer advances by one, modulo 64, on every J1 byte (row code 0). With insertion on, J1 is sent from the entry the pointer selects. With insertion off, J1 passes through and is stored into that entry.
- R4: With insertion on, the B3 byte (row code 1) equals the even-parity BIP-8 of all transmitted bytes that carried the envelope strobe since the previous frame strobe, up to the byte before it. A frame-strobe byte that carries the envelope strobe opens the new sum. The result is XORed with the mask register at 0x1D0. After reset the first sum is zero.
- R5: With the one-shot bit (bit 1 of 0x1D1) set, the mask clears after it has been applied to one inserted B3 byte. With the bit clear, the mask is applied on every frame.
- R6: With insertion on, the G1 byte (row code 3) carries min(febeIn, 8) in bits 7..4 and bits 3..0 of the register at 0x1CA. Bit 3 of that register is the path yellow flag.
- R7: A write to a register in 0x1C9..0x1D1 takes effect at the next frame strobe. A write in the same cycle as a frame strobe waits for the strobe after that.
- R8: A write to 0x180 + n (n from 0 to 63) updates trace entry n at once.
- R9: outByte follows inByte by exactly one clock and is 0x00 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inByte | input | 8 | Incoming transmit byte |
| frameStrobe | input | 1 | High on the first byte of a frame |
| speStrobe | input | 1 | High on bytes covered by the path BIP-8 |
| pohStrobe | input | 1 | High on a path overhead byte |
| pohRow | input | 4 | Overhead row code: 0 J1, 1 B3, 2 C2, 3 G1, 4 F2, 5 H4, 6 Z3, 7 Z4, 8 Z5 |
| febeIn | input | 4 | Far-end block error count from the receive side |
| hostWe | input | 1 | Host write enable |
| hostAddr | input | 9 | Host write address |
| hostData | input | 8 | Host write data |
| outByte | output | 8 | Transmitted byte, one clock after inByte |

## Verification
Every transmitted byte is due exactly one clock after its input byte. The bench drives each byte on the falling edge, waits for the next rising edge and samples just after it. Register writes only show up on overhead bytes that follow the next frame strobe, so the bench's expected value for each byte is computed from its model state before the clock edge that consumes that byte. B3 depends on the bytes actually sent in the whole previous frame. The model therefore folds each expected output byte into its parity sum, in the same cycle that byte is checked.

// File: rtl/pohInsPkg.sv
package pohInsPkg;
  localparam int DATA_W   = 8;
  localparam int TRACE_AW = 6;
  localparam int FEBE_W   = 4;

  typedef enum logic [3:0] {
    ROW_J1 = 4'd0, ROW_B3 = 4'd1, ROW_C2 = 4'd2, ROW_G1 = 4'd3, ROW_F2 = 4'd4,
    ROW_H4 = 4'd5, ROW_Z3 = 4'd6, ROW_Z4 = 4'd7, ROW_Z5 = 4'd8
  } pohRowE;

  // strobes from control to datapath, valid in the cycle of the byte
  typedef struct packed {
    logic                useReg;
    logic [DATA_W-1:0]   regByte;
    logic                useTrace;
    logic                capTrace;
    logic [TRACE_AW-1:0] tracePtr;
    logic                useB3;
    logic [DATA_W-1:0]   mask;
    logic                useG1;
    logic [FEBE_W-1:0]   febe;
  } ctrlStrobesT;
endpackage

// File: rtl/pohInsCtrl.sv
module pohInsCtrl
  import pohInsPkg::*;
#(
  parameter int          ADDR_W     = 9,
  parameter logic [8:0]  TRACE_BASE = 9'h180,
  parameter logic [8:0]  REG_BASE   = 9'h1C9,
  parameter int          FEBE_MAX   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frameStrobe,
  input  logic                pohStrobe,
  input  logic [3:0]          pohRow,
  input  logic [FEBE_W-1:0]   febeIn,
  input  logic                hostWe,
  input  logic [ADDR_W-1:0]   hostAddr,
  input  logic [DATA_W-1:0]   hostData,
  output ctrlStrobesT         cs,
  output logic                traceWe,
  output logic [TRACE_AW-1:0] traceAddr,
  output logic [DATA_W-1:0]   traceData
);
  localparam int NREG       = 9;
  localparam int IDX_G1     = 1;
  localparam int IDX_MASK   = 7;
  localparam int IDX_CTRL   = 8;
  localparam int TRACE_N    = 1 << TRACE_AW;

  logic [NREG-1:0][DATA_W-1:0] shadowQ, activeQ;
  logic [NREG-1:0]             pendQ;
  logic [TRACE_AW-1:0]         ptrQ;

  logic       regHit, pathIns, oneShot, consume;
  logic       isJ1, isB3, isG1, isFixed;
  logic [3:0] regIdx, rowIdx;

  assign regHit  = hostWe && (hostAddr >= REG_BASE) && (hostAddr <= ADDR_W'(REG_BASE + NREG - 1));
  assign regIdx  = 4'(hostAddr - REG_BASE);
  assign traceWe = hostWe && (hostAddr >= TRACE_BASE) && (hostAddr <= ADDR_W'(TRACE_BASE + TRACE_N - 1));
  assign traceAddr = hostAddr[TRACE_AW-1:0];
  assign traceData = hostData;

  assign pathIns = activeQ[IDX_CTRL][0];
  assign oneShot = activeQ[IDX_CTRL][1];

  assign isJ1 = pohStrobe && (pohRow == ROW_J1);
  assign isB3 = pohStrobe && (pohRow == ROW_B3);
  assign isG1 = pohStrobe && (pohRow == ROW_G1);

  always_comb begin
    isFixed = pohStrobe;
    rowIdx  = 4'd0;
    case (pohRow)
      ROW_C2:  rowIdx = 4'd0;
      ROW_F2:  rowIdx = 4'd2;
      ROW_Z3:  rowIdx = 4'd4;
      ROW_Z4:  rowIdx = 4'd5;
      ROW_Z5:  rowIdx = 4'd6;
      default: isFixed = 1'b0;
    endcase
  end

  assign consume = pathIns && isB3 && oneShot;

  always_comb begin
    cs          = '0;
    cs.useReg   = pathIns && isFixed;
    cs.regByte  = isG1 ? activeQ[IDX_G1] : activeQ[rowIdx];
    cs.useTrace = pathIns && isJ1;
    cs.capTrace = !pathIns && isJ1;
    cs.tracePtr = ptrQ;
    cs.useB3    = pathIns && isB3;
    cs.mask     = activeQ[IDX_MASK];
    cs.useG1    = pathIns && isG1;
    cs.febe     = (febeIn > FEBE_W'(FEBE_MAX)) ? FEBE_W'(FEBE_MAX) : febeIn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadowQ <= '0;
      activeQ <= '0;
      pendQ   <= '0;
      ptrQ    <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (frameStrobe && pendQ[i])
          activeQ[i] <= shadowQ[i];
        else if (i == IDX_MASK && consume)
          activeQ[i] <= '0;
        if (regHit && regIdx == 4'(i)) begin
          shadowQ[i] <= hostData;
          pendQ[i]   <= 1'b1;
        end else if (frameStrobe) begin
          pendQ[i] <= 1'b0;
        end
      end
      if (isJ1) ptrQ <= ptrQ + 1'b1;
    end
  end

  p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    isJ1 |=> ptrQ == TRACE_AW'($past(ptrQ) + 1'b1));
  p_oneshot_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && !(frameStrobe && pendQ[IDX_MASK])) |=> activeQ[IDX_MASK] == '0);
  p_febe_clamp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cs.useG1 |-> cs.febe <= FEBE_W'(FEBE_MAX));
  p_commit_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !frameStrobe |=> $stable(activeQ[0]));
endmodule

// File: rtl/pohInsData.sv
module pohInsData
  import pohInsPkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DATA_W-1:0]   inByte,
  input  logic                frameStrobe,
  input  logic                speStrobe,
  input  ctrlStrobesT         cs,
  input  logic                traceWe,
  input  logic [TRACE_AW-1:0] traceAddr,
  input  logic [DATA_W-1:0]   traceData,
  output logic [DATA_W-1:0]   outByte
);
  localparam int TRACE_N = 1 << TRACE_AW;
  localparam int LOW_W   = DATA_W - FEBE_W;

  logic [DATA_W-1:0] traceMem [TRACE_N];
  logic [DATA_W-1:0] bipAccQ, bipHoldQ, nextByte;

  always_comb begin
    if (cs.useTrace)    nextByte = traceMem[cs.tracePtr];
    else if (cs.useB3)  nextByte = bipHoldQ ^ cs.mask;
    else if (cs.useG1)  nextByte = {cs.febe, cs.regByte[LOW_W-1:0]};
    else if (cs.useReg) nextByte = cs.regByte;
    else                nextByte = inByte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outByte  <= '0;
      bipAccQ  <= '0;
      bipHoldQ <= '0;
      for (int i = 0; i < TRACE_N; i++) traceMem[i] <= '0;
    end else begin
      outByte <= nextByte;
      if (frameStrobe) begin
        bipHoldQ <= bipAccQ;
        bipAccQ  <= speStrobe ? nextByte : '0;
      end else if (speStrobe) begin
        bipAccQ <= bipAccQ ^ nextByte;
      end
      if (traceWe) traceMem[traceAddr] <= traceData;
      if (cs.capTrace) traceMem[cs.tracePtr] <= inByte;
    end
  end

  p_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs.useReg || cs.useTrace || cs.useB3 || cs.useG1) |=> outByte == $past(inByte));
  p_g1_nibble_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cs.useG1 |=> outByte[DATA_W-1:LOW_W] == $past(cs.febe));
endmodule

// File: rtl/pohInsert.sv
module pohInsert
  import pohInsPkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  inByte,
  input  logic        frameStrobe,
  input  logic        speStrobe,
  input  logic        pohStrobe,
  input  logic [3:0]  pohRow,
  input  logic [3:0]  febeIn,
  input  logic        hostWe,
  input  logic [8:0]  hostAddr,
  input  logic [7:0]  hostData,
  output logic [7:0]  outByte
);
  ctrlStrobesT         cs;
  logic                traceWe;
  logic [TRACE_AW-1:0] traceAddr;
  logic [DATA_W-1:0]   traceData;

  pohInsCtrl uCtrl (
    .clk(clk), .rst_n(rst_n), .frameStrobe(frameStrobe), .pohStrobe(pohStrobe),
    .pohRow(pohRow), .febeIn(febeIn), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostData(hostData), .cs(cs), .traceWe(traceWe), .traceAddr(traceAddr),
    .traceData(traceData)
  );

  pohInsData uData (
    .clk(clk), .rst_n(rst_n), .inByte(inByte), .frameStrobe(frameStrobe),
    .speStrobe(speStrobe), .cs(cs), .traceWe(traceWe), .traceAddr(traceAddr),
    .traceData(traceData), .outByte(outByte)
  );

  p_h4_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pohStrobe && pohRow == ROW_H4) |=> outByte == $past(inByte));
  p_reset_out_r9: assert property (@(posedge clk)
    !rst_n |-> outByte == 8'h00);
endmodule

// File: tb/tb_pohInsert.sv
module tb_pohInsert;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] inByte = '0;
  logic       frameStrobe = 1'b0, speStrobe = 1'b0, pohStrobe = 1'b0;
  logic [3:0] pohRow = '0, febeIn = '0;
  logic       hostWe = 1'b0;
  logic [8:0] hostAddr = '0;
  logic [7:0] hostData = '0;
  logic [7:0] outByte;

  int nChecks = 0, nFails = 0;
  string focus = "";

  // bench model state
  logic [7:0] mShadow [9], mActive [9];
  logic [8:0] mPend;
  logic [7:0] mMem [64];
  logic [5:0] mPtr;
  logic [7:0] mAcc, mHold;

  always #4 clk = ~clk;

  pohInsert dut (.*);

  function automatic string rowTag(input logic poh, input logic [3:0] row);
    if (!poh) return "R9";
    case (row)
      4'd0: return "R3";
      4'd1: return "R4";
      4'd3: return "R6";
      4'd5: return "R2";
      default: return "R1";
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: out=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [7:0] b, input logic fs, input logic spe, input logic poh,
                      input logic [3:0] row, input logic we, input logic [8:0] a, input logic [7:0] d);
    logic [7:0] exp;
    logic pI, os, clr;
    logic [3:0] fb;
    @(negedge clk);
    inByte = b; frameStrobe = fs; speStrobe = spe; pohStrobe = poh; pohRow = row;
    hostWe = we; hostAddr = a; hostData = d;
    pI = mActive[8][0]; os = mActive[8][1];
    fb = (febeIn > 4'd8) ? 4'd8 : febeIn;
    exp = b;
    if (poh && pI)
      case (row)
        4'd0: exp = mMem[mPtr];
        4'd1: exp = mHold ^ mActive[7];
        4'd2: exp = mActive[0];
        4'd3: exp = {fb, mActive[1][3:0]};
        4'd4: exp = mActive[2];
        4'd6: exp = mActive[4];
        4'd7: exp = mActive[5];
        4'd8: exp = mActive[6];
        default: exp = b;
      endcase
    clr = poh && row == 4'd1 && pI && os;
    for (int i = 0; i < 9; i++) begin
      if (fs && mPend[i]) mActive[i] = mShadow[i];
      else if (i == 7 && clr) mActive[i] = 8'h00;
    end
    if (fs) mPend = '0;
    if (we && a >= 9'h1C9 && a <= 9'h1D1) begin
      mShadow[a - 9'h1C9] = d;
      mPend[a - 9'h1C9] = 1'b1;
    end
    if (we && a >= 9'h180 && a <= 9'h1BF) mMem[a[5:0]] = d;
    if (poh && row == 4'd0) begin
      if (!pI) mMem[mPtr] = b;
      mPtr = mPtr + 1'b1;
    end
    if (fs) begin mHold = mAcc; mAcc = spe ? exp : 8'h00; end
    else if (spe) mAcc = mAcc ^ exp;
    @(posedge clk); #1;
    check(focus != "" ? focus : rowTag(poh, row), outByte, exp);
  endtask

  task automatic hostWrite(input logic [8:0] a, input logic [7:0] d);
    step(8'($urandom), 1'b0, 1'b0, 1'b0, 4'd0, 1'b1, a, d);
  endtask

  // 24-byte frame: byte 0 frame strobe, bytes 3..23 envelope, overhead on odd bytes 3..19
  task automatic sendFrame(input int wrAt, input logic [8:0] wa, input logic [7:0] wd);
    for (int k = 0; k < 24; k++) begin
      logic poh;
      poh = (k >= 3) && (k <= 19) && (((k - 3) % 2) == 0);
      step(8'($urandom), k == 0, k >= 3, poh, poh ? 4'((k - 3) / 2) : 4'd0,
           k == wrAt, wa, wd);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: out=%02h expected=done", outByte);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 9; i++) begin mShadow[i] = '0; mActive[i] = '0; end
    for (int i = 0; i < 64; i++) mMem[i] = '0;
    mPend = '0; mPtr = '0; mAcc = '0; mHold = '0;
    repeat (3) @(posedge clk);
    #1 check("R9", outByte, 8'h00);
    @(negedge clk) rst_n = 1'b1;

    // pass-through with insertion off; J1 bytes captured into trace
    for (int f = 0; f < 3; f++) sendFrame(-1, '0, '0);

    // load insert registers, continuous mask
    hostWrite(9'h1C9, 8'hC2); hostWrite(9'h1CA, 8'h0D); hostWrite(9'h1CB, 8'hF2);
    hostWrite(9'h1CD, 8'h33); hostWrite(9'h1CE, 8'h44); hostWrite(9'h1CF, 8'h55);
    hostWrite(9'h1CC, 8'hEE); hostWrite(9'h1D0, 8'h5A); hostWrite(9'h1D1, 8'h01);
    for (int f = 0; f < 3; f++) begin
      febeIn = 4'($urandom_range(0, 15));
      sendFrame(-1, '0, '0);
    end
    febeIn = 4'd15; sendFrame(-1, '0, '0);
    febeIn = 4'd8;  sendFrame(-1, '0, '0);

    // one-shot mask
    focus = "R5";
    hostWrite(9'h1D0, 8'h81); hostWrite(9'h1D1, 8'h03);
    for (int f = 0; f < 3; f++) sendFrame(-1, '0, '0);
    hostWrite(9'h1D1, 8'h01);
    sendFrame(-1, '0, '0);

    // write mid-frame before C2 slot, and on the frame strobe itself
    focus = "R7";
    sendFrame(4, 9'h1C9, 8'hA7);
    sendFrame(-1, '0, '0);
    sendFrame(0, 9'h1CB, 8'h6B);
    sendFrame(-1, '0, '0);
    sendFrame(-1, '0, '0);

    // direct trace writes
    focus = "R8";
    for (int i = 0; i < 8; i++) hostWrite(9'h180 + 9'(mPtr + 6'(i)), 8'(8'h90 + i));
    for (int f = 0; f < 8; f++) sendFrame(-1, '0, '0);
    focus = "";

    // random phase, runs the trace pointer through wraparound
    for (int f = 0; f < 90; f++) begin
      int sel;
      febeIn = 4'($urandom_range(0, 15));
      sel = $urandom_range(0, 5);
      case (sel)
        0: sendFrame($urandom_range(0, 23), 9'h1D1, 8'($urandom_range(0, 3)));
        1: sendFrame($urandom_range(0, 23), 9'h1D0, 8'($urandom));
        2: sendFrame($urandom_range(0, 23), 9'h1C9 + 9'($urandom_range(0, 6)), 8'($urandom));
        3: sendFrame($urandom_range(0, 23), 9'h180 + 9'($urandom_range(0, 63)), 8'($urandom));
        default: sendFrame(-1, '0, '0);
      endcase
    end

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule